// File: doc/BRIEF.md
# PLL Divider and Phase Comparator Core

This block holds the digital part of a frequency synthesizer loop. A programmable divider counts the rising edges of the VCO clock, which arrives already prescaled by eight, and emits one pulse every N edges. N is a 15-bit word. Values below a floor are raised to that floor, and a new word takes effect only at the divider's next terminal count. A second divider counts crystal edges and emits one pulse every R edges, where R is a base ratio shifted left by a two-bit select. The synthesized frequency is therefore N × 8 × (crystal / R).

A three-state phase comparator watches the two pulse streams. When the divided VCO pulse comes first, it raises a source enable until the reference pulse arrives. When the reference comes first, it raises a sink enable until the divided VCO pulse arrives. When the two pulses coincide, both enables stay low, which the analog charge pump reads as high impedance. A lock flag counts comparisons whose error, measured in system clock cycles, is below a window. A two-bit test field routes either divided pulse stream to a monitor output.

Both incoming clocks are sampled by the system clock `clk` through synchronizer stages of equal depth. Their relative timing is therefore preserved, and all phase errors are measured in `clk` cycles.

Top module: `pll_divphase_core`

## Requirements
- R1: While `rst_n` is low and until the first divided pulse after its release, `src_en`, `snk_en`, `lock` and `mon_out` are low.
- R2: For a ratio word N at or above `N_MIN`, the divided VCO pulse repeats once every N rising edges of `vco_div8_in`. With a steady input period of T cycles, the pulse period is N·T cycles.
- R3: A ratio word below `N_MIN` divides by `N_MIN`.
- R4: A change of `n_word` has no effect on the division period in progress. That period ends with the old ratio, and the period that follows uses the new one, with no shortened period between them.
- R5: The reference divider divides crystal edges by `REF_BASE << ref_sel`. With the default base of 512, `ref_sel` = 01 gives 1024.
- R6: When the divided VCO pulse leads the divided reference pulse by d cycles, `src_en` is high for exactly d cycles and `snk_en` stays low.
- R7: When the divided VCO pulse lags the reference pulse by d cycles, `snk_en` is high for exactly d cycles and `src_en` stays low.
- R8: When both divided pulses arrive in the same cycle, neither enable rises, and the two enables are never high together.
- R9: `lock` rises right after the `LOCK_CNT`-th consecutive comparison whose error (the enable width in cycles, 0 for a coincidence) is below `LOCK_WIN`, and not before it.
- R10: `lock` falls right after the first comparison whose error is `LOCK_WIN` cycles or more.
- R11: `mon_out` carries, one cycle after the event: nothing for `test_sel` = 00, the divided VCO pulse for 01, the divided reference pulse for 10, and either pulse for 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| vco_div8_in | input | 1 | VCO clock after the divide-by-8 prescaler |
| xtal_in | input | 1 | Crystal reference clock |
| n_word | input | N_W | Programmable divide ratio N |
| ref_sel | input | 2 | Reference ratio select (shift of REF_BASE) |
| test_sel | input | 2 | Monitor routing select |
| src_en | output | 1 | Charge-pump source enable (VCO leads) |
| snk_en | output | 1 | Charge-pump sink enable (VCO lags) |
| lock | output | 1 | Loop lock flag |
| mon_out | output | 1 | Monitor pulse output |

## Verification
The bench builds the core with `N_MIN` = 8, `REF_BASE` = 4, `LOCK_WIN` = 3 and `LOCK_CNT` = 4, keeping `N_W` at 15. With these values the VCO and reference divisions line up at 32 cycles, using a 4-cycle VCO input and an 8-cycle crystal input. A single run therefore spans dozens of comparisons. The floor clamp, the mid-period ratio change and a lock followed by a loss of lock all fit in a few hundred cycles. Input phase offsets drawn at random give lead and lag errors from −11 to +3 cycles, which fall on both sides of the lock window.

// File: rtl/pdl_pkg.sv
package pdl_pkg;

  typedef enum logic [1:0] {
    PD_IDLE = 2'd0,
    PD_LEAD = 2'd1,
    PD_LAG  = 2'd2
  } pd_state_t;

  // Raise a ratio word to the divider's floor value.
  function automatic int unsigned floor_ratio(input int unsigned r,
                                              input int unsigned rmin);
    return (r < rmin) ? rmin : r;
  endfunction

  // Reference ratio: base shifted left by the select code.
  function automatic int unsigned ref_ratio(input int unsigned base,
                                            input logic [1:0] sel);
    return base << sel;
  endfunction

endpackage

// File: rtl/pdl_edge_sync.sv
module pdl_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_in,
  output logic rise_o
);

  logic [STAGES:0] sync_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-1:0], d_in};
  end

  assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];

endmodule

// File: rtl/pdl_prog_div.sv
module pdl_prog_div #(
  parameter int CW   = 15,
  parameter int RMIN = 1024
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic [CW-1:0] ratio_i,
  output logic          term_o
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] n_act_q;
  logic [CW-1:0] ratio_eff;
  logic          at_term;

  assign ratio_eff = CW'(pdl_pkg::floor_ratio(32'(ratio_i), RMIN));
  assign at_term   = tick_i && (cnt_q >= (n_act_q - CW'(1)));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      n_act_q <= ratio_eff;
      term_o  <= 1'b0;
    end else begin
      term_o <= at_term;
      if (tick_i) begin
        if (at_term) begin
          cnt_q   <= '0;
          n_act_q <= ratio_eff;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  // R4
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !at_term |=> $stable(n_act_q));

  // R2
  term_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    term_o |-> $past(tick_i));

endmodule

// File: rtl/pdl_phase_cmp.sv
module pdl_phase_cmp #(
  parameter int EW       = 6,
  parameter int LOCK_WIN = 3,
  parameter int LOCK_CNT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fv_i,
  input  logic fr_i,
  output logic src_en_o,
  output logic snk_en_o,
  output logic lock_o
);
  import pdl_pkg::*;

  localparam int GW = $clog2(LOCK_CNT + 1);

  pd_state_t     state_q, state_d;
  logic [EW-1:0] err_q, err_d, err_now;
  logic [GW-1:0] good_q;
  logic          cmp_done, cmp_good;

  always_comb begin
    state_d  = state_q;
    cmp_done = 1'b0;
    err_now  = '0;
    unique case (state_q)
      PD_IDLE: begin
        if (fv_i && fr_i)  cmp_done = 1'b1;
        else if (fv_i)     state_d  = PD_LEAD;
        else if (fr_i)     state_d  = PD_LAG;
      end
      PD_LEAD: if (fr_i) begin
        cmp_done = 1'b1;
        err_now  = err_q;
        state_d  = PD_IDLE;
      end
      PD_LAG: if (fv_i) begin
        cmp_done = 1'b1;
        err_now  = err_q;
        state_d  = PD_IDLE;
      end
      default: state_d = PD_IDLE;
    endcase
  end

  always_comb begin
    if (state_q == PD_IDLE && state_d != PD_IDLE) err_d = EW'(1);
    else if (state_q != PD_IDLE && state_d == state_q)
      err_d = (err_q == '1) ? err_q : err_q + EW'(1);
    else err_d = '0;
  end

  assign cmp_good = cmp_done && (32'(err_now) < LOCK_WIN);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PD_IDLE;
      err_q   <= '0;
      good_q  <= '0;
    end else begin
      state_q <= state_d;
      err_q   <= err_d;
      if (cmp_done) begin
        if (!cmp_good)                     good_q <= '0;
        else if (good_q != GW'(LOCK_CNT))  good_q <= good_q + GW'(1);
      end
    end
  end

  assign src_en_o = (state_q == PD_LEAD);
  assign snk_en_o = (state_q == PD_LAG);
  assign lock_o   = (good_q == GW'(LOCK_CNT));

  // R8
  coincide_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_IDLE && fv_i && fr_i) |=> (!src_en_o && !snk_en_o));

  // R6
  lead_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_IDLE && fv_i && !fr_i) |=> src_en_o);

  // R7
  lag_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PD_IDLE && fr_i && !fv_i) |=> snk_en_o);

  // R9
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock_o) |-> $past(cmp_good));

  // R10
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_done && !cmp_good) |=> !lock_o);

endmodule

// File: rtl/pll_divphase_core.sv
module pll_divphase_core #(
  parameter int N_W         = 15,
  parameter int N_MIN       = 1024,
  parameter int REF_BASE    = 512,
  parameter int SYNC_STAGES = 2,
  parameter int EW          = 6,
  parameter int LOCK_WIN    = 3,
  parameter int LOCK_CNT    = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           vco_div8_in,
  input  logic           xtal_in,
  input  logic [N_W-1:0] n_word,
  input  logic [1:0]     ref_sel,
  input  logic [1:0]     test_sel,
  output logic           src_en,
  output logic           snk_en,
  output logic           lock,
  output logic           mon_out
);

  localparam int REF_MAX = REF_BASE * 8;
  localparam int RW      = $clog2(REF_MAX + 1);

  logic          vco_rise, xtal_rise;
  logic          fv_pulse, fr_pulse;
  logic [RW-1:0] ref_ratio_w;

  assign ref_ratio_w = RW'(pdl_pkg::ref_ratio(REF_BASE, ref_sel));

  pdl_edge_sync #(.STAGES(SYNC_STAGES)) vco_sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(vco_div8_in), .rise_o(vco_rise));

  pdl_edge_sync #(.STAGES(SYNC_STAGES)) xtal_sync_i (
    .clk(clk), .rst_n(rst_n), .d_in(xtal_in), .rise_o(xtal_rise));

  pdl_prog_div #(.CW(N_W), .RMIN(N_MIN)) n_div_i (
    .clk(clk), .rst_n(rst_n), .tick_i(vco_rise),
    .ratio_i(n_word), .term_o(fv_pulse));

  pdl_prog_div #(.CW(RW), .RMIN(REF_BASE)) r_div_i (
    .clk(clk), .rst_n(rst_n), .tick_i(xtal_rise),
    .ratio_i(ref_ratio_w), .term_o(fr_pulse));

  pdl_phase_cmp #(.EW(EW), .LOCK_WIN(LOCK_WIN), .LOCK_CNT(LOCK_CNT)) pd_i (
    .clk(clk), .rst_n(rst_n), .fv_i(fv_pulse), .fr_i(fr_pulse),
    .src_en_o(src_en), .snk_en_o(snk_en), .lock_o(lock));

  always_ff @(posedge clk) begin
    if (!rst_n) mon_out <= 1'b0;
    else begin
      unique case (test_sel)
        2'b01:   mon_out <= fv_pulse;
        2'b10:   mon_out <= fr_pulse;
        2'b11:   mon_out <= fv_pulse | fr_pulse;
        default: mon_out <= 1'b0;
      endcase
    end
  end

  // R11
  mon_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_sel == 2'b00) |=> !mon_out);

  // R11
  mon_vco_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (test_sel == 2'b01) |=> (mon_out == $past(fv_pulse)));

endmodule

// File: tb/pll_divphase_core_tb_top.sv
module pll_divphase_core_tb_top;

  localparam int N_W = 15, N_MIN = 8, REF_BASE = 4, LOCK_WIN = 3, LOCK_CNT = 4;

  logic clk = 1'b0, rst_n = 1'b0, vco_in = 1'b0, xtal = 1'b0;
  logic [N_W-1:0] n_word = '0;
  logic [1:0] ref_sel = '0, test_sel = '0;
  logic src_en, snk_en, lock, mon_out;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0;

  int src_cnt, src_w, snk_cnt, snk_w, mon_cnt, per_n;
  int per [0:31];
  int per_end [0:31];
  bit lk [0:15];
  bit bad_seen, bad_lock, lock_ever, both_hi, early_out;

  always #5 clk = ~clk;

  pll_divphase_core #(.N_W(N_W), .N_MIN(N_MIN), .REF_BASE(REF_BASE),
    .LOCK_WIN(LOCK_WIN), .LOCK_CNT(LOCK_CNT)) dut_i (
    .clk(clk), .rst_n(rst_n), .vco_div8_in(vco_in), .xtal_in(xtal),
    .n_word(n_word), .ref_sel(ref_sel), .test_sel(test_sel),
    .src_en(src_en), .snk_en(snk_en), .lock(lock), .mon_out(mon_out));

  function automatic int exp_n(input int n);
    return (n < N_MIN) ? N_MIN : n;
  endfunction

  function automatic int exp_r(input int sel);
    return REF_BASE * (1 << sel);
  endfunction

  // Lead of the divided VCO pulse over the reference, in clk cycles.
  function automatic int exp_lead(input int n, input int tv, input int r,
                                  input int tr, input int ov, input int ofr);
    return (ofr + (r - 1) * tr) - (ov + (n - 1) * tv);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int n1, input int n2, input int cc, input int sel,
                          input int tsel, input int tv, input int tr,
                          input int ov, input int ofr, input int ncyc);
    int srun = 0, krun = 0, last_t = -1;
    src_cnt = 0; src_w = 0; snk_cnt = 0; snk_w = 0; mon_cnt = 0; per_n = 0;
    bad_seen = 0; bad_lock = 0; lock_ever = 0; both_hi = 0; early_out = 0;
    for (int i = 0; i < 16; i++) lk[i] = 0;
    @(negedge clk);
    rst_n = 0; vco_in = 0; xtal = 0;
    n_word = N_W'(n1); ref_sel = 2'(sel); test_sel = 2'(tsel);
    repeat (3) begin
      @(negedge clk);
      if (src_en || snk_en || lock || mon_out) early_out = 1;
    end
    rst_n = 1;
    for (int c = 0; c < ncyc; c++) begin
      @(negedge clk);
      if (c < 6 && (src_en || snk_en || lock || mon_out)) early_out = 1;
      if (src_en && snk_en) both_hi = 1;
      if (lock) lock_ever = 1;
      if (src_en) srun++;
      else if (srun > 0) begin
        if (src_cnt < 16) lk[src_cnt] = lock;
        src_cnt++; src_w = srun;
        if (srun >= LOCK_WIN && !bad_seen) begin bad_seen = 1; bad_lock = lock; end
        srun = 0;
      end
      if (snk_en) krun++;
      else if (krun > 0) begin
        snk_cnt++; snk_w = krun;
        if (krun >= LOCK_WIN && !bad_seen) begin bad_seen = 1; bad_lock = lock; end
        krun = 0;
      end
      if (mon_out) begin
        mon_cnt++;
        if (last_t >= 0 && per_n < 32) begin
          per[per_n] = c - last_t; per_end[per_n] = c; per_n++;
        end
        last_t = c;
      end
      if (c == cc) n_word = N_W'(n2);
      vco_in = (c >= ov) && (((c - ov) % tv) < tv / 2);
      xtal   = (c >= ofr) && (((c - ofr) % tr) < tr / 2);
    end
  endtask

  task automatic chk_phase(input int d, input string tag);
    if (d > 0) begin
      chk(src_cnt >= 3 && src_w == d, {tag, " R6 lead width"}, src_w, d);
      chk(snk_cnt == 0, {tag, " R6 sink idle"}, snk_cnt, 0);
    end else if (d < 0) begin
      chk(snk_cnt >= 3 && snk_w == -d, {tag, " R7 lag width"}, snk_w, -d);
      chk(src_cnt == 0, {tag, " R7 source idle"}, src_cnt, 0);
    end else begin
      chk(src_cnt == 0 && snk_cnt == 0, {tag, " R8 coincidence quiet"},
          src_cnt + snk_cnt, 0);
    end
    chk(!both_hi, {tag, " R8 exclusive enables"}, int'(both_hi), 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int seed, d, n, sel, ov, ofr, k;
    seed = $urandom(32'd4242);

    // R1 reset state plus R6/R9 lead with lock: lead of 2 cycles
    run_case(8, 8, -1, 0, 1, 4, 8, 0, 6, 450);
    chk(!early_out, "R1 outputs low in and after reset", int'(early_out), 0);
    d = exp_lead(8, 4, 4, 8, 0, 6);
    chk_phase(d, "directed");
    chk(lk[2] == 0, "R9 no lock after third good comparison", int'(lk[2]), 0);
    chk(lk[3] == 1, "R9 lock after fourth good comparison", int'(lk[3]), 1);
    chk(per_n > 2 && per[per_n-1] == 32, "R2 divide by 8", per[per_n-1], 32);

    // R7 lag of 8 cycles, never locks
    run_case(8, 8, -1, 0, 0, 4, 8, 4, 0, 400);
    chk_phase(exp_lead(8, 4, 4, 8, 4, 0), "directed");
    chk(!lock_ever, "R10 wide lag never locks", int'(lock_ever), 0);
    chk(mon_cnt == 0, "R11 monitor off for code 00", mon_cnt, 0);

    // R8 coincidence with monitor on both pulses
    run_case(8, 8, -1, 0, 3, 4, 8, 4, 8, 400);
    chk_phase(exp_lead(8, 4, 4, 8, 4, 8), "directed");
    chk(lock_ever, "R9 lock on coincident comparisons", int'(lock_ever), 1);
    chk(per_n > 2 && per[per_n-1] == 32, "R11 monitor code 11 period", per[per_n-1], 32);

    // R3 clamp of a small ratio word
    run_case(3, 3, -1, 0, 1, 4, 8, 0, 0, 300);
    chk(per_n > 2 && per[per_n-1] == exp_n(3) * 4, "R3 clamp to floor", per[per_n-1], exp_n(3) * 4);

    // R2 odd ratio
    run_case(13, 13, -1, 0, 1, 4, 8, 0, 0, 400);
    chk(per_n > 2 && per[per_n-1] == 52, "R2 divide by 13", per[per_n-1], 52);

    // R5 reference select 01 on the monitor
    run_case(8, 8, -1, 1, 2, 4, 4, 0, 0, 300);
    chk(per_n > 2 && per[per_n-1] == exp_r(1) * 4, "R5 reference select 01", per[per_n-1], exp_r(1) * 4);

    // R4 ratio change in mid-period: spanning period old, next one new
    run_case(8, 10, 200, 0, 1, 4, 8, 0, 0, 500);
    k = -1;
    for (int i = 0; i < per_n; i++)
      if (k < 0 && per_end[i] - per[i] < 200 && per_end[i] > 200) k = i;
    chk(k >= 0 && per[k] == 32, "R4 period in progress keeps old ratio", (k >= 0) ? per[k] : -1, 32);
    chk(k >= 0 && k + 1 < per_n && per[k+1] == 40, "R4 next period uses new ratio",
        (k >= 0 && k + 1 < per_n) ? per[k+1] : -1, 40);
    for (int i = 0; i < per_n; i++)
      chk(per[i] == 32 || per[i] == 40, "R4 no runt period", per[i], 32);

    // R10 lock lost on the first wide error after a ratio change
    run_case(8, 9, 200, 0, 0, 4, 8, 4, 8, 400);
    chk(lock_ever, "R10 locked before ratio change", int'(lock_ever), 1);
    chk(bad_seen && !bad_lock, "R10 lock falls on first wide error", int'(bad_lock), 0);

    // Random ratio words (R2, R3)
    for (int it = 0; it < 6; it++) begin
      n = 4 + int'($urandom % 12);
      run_case(n, n, -1, 0, 1, 4, 8, 0, 0, 420);
      chk(per_n > 2 && per[per_n-1] == exp_n(n) * 4,
          (n < N_MIN) ? "R3 random clamp" : "R2 random ratio", per[per_n-1], exp_n(n) * 4);
    end

    // Random reference selects (R5)
    for (int it = 0; it < 4; it++) begin
      sel = int'($urandom % 4);
      run_case(8, 8, -1, sel, 2, 4, 4, 0, 0, 700);
      chk(per_n > 2 && per[per_n-1] == exp_r(sel) * 4, "R5 random select",
          per[per_n-1], exp_r(sel) * 4);
    end

    // Random phase offsets (R6, R7, R8)
    for (int it = 0; it < 8; it++) begin
      ov  = int'($urandom % 8);
      ofr = int'($urandom % 8);
      run_case(8, 8, -1, 0, 0, 4, 8, ov, ofr, 360);
      chk_phase(exp_lead(8, 4, 4, 8, ov, ofr), "random");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule